// File: doc/BRIEF.md
# Passive I2C Bus Monitor

This block listens to an I2C bus and never takes part in it. SCL and SDA come in through a synchronizer. The block finds START, repeated START and STOP conditions, shifts in each 9-clock word, and decides from the first byte after a START whether the transfer is of interest. That happens in one of two ways: the 7-bit address equals one of several programmable address registers, or, in monitor mode with match-all set, any address counts.

Once a transfer is selected, every following byte raises the interrupt. This holds whether the master writes, or the addressed slave drives the data in a read. Software reads the byte from a data register. It can also read a buffer register that keeps the whole 9-bit word, so the next word can arrive before software responds. Optionally, while an interrupt is pending, the block holds SCL low after the acknowledge clock to give software time. The block has no SDA driver at all, so it cannot acknowledge, transmit or win or lose arbitration.

Control is a simple register port with a write strobe, a read strobe, an address and 32-bit data. Reads are combinational.

Top module: `i2c_bus_listener`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 7) read 0, `irq_o` is 0 and `scl_hold_o` is 0.
- R2: The control register has bit0 = monitor mode, bit1 = clock-hold enable and bit2 = match-all. When match-all is not in effect, an address byte (upper 7 bits = address, bit0 = R/W) raises the interrupt only if it equals one of the address registers at register addresses 1 to 4. Status then reports the lowest matching register index in bits [3:2] and bit6 = 1.
- R3: With monitor mode and match-all both set, every address raises the interrupt. Status bit6 = 0 and bits [3:2] = 0 when no register matched.
- R4: With monitor mode cleared, match-all and clock-hold enable have no effect: filtering is by address register only and `scl_hold_o` stays 0.
- R5: In a selected write transfer, each data byte raises the interrupt. The data register (address 5) gets the byte. The buffer register (address 6) gets {byte, SDA level in the 9th clock}, with the byte in bits [8:1].
- R6: In a selected read transfer, status bit1 = 1 and each byte that the slave drives is captured as it appeared on SDA.
- R7: Bytes that follow an address that was not selected raise no interrupt.
- R8: A STOP raises no interrupt and ends the selection. Status bit7 (bus active) is 1 between a START and a STOP. A repeated START makes the next byte an address that is judged afresh.
- R9: If a word is captured while the buffer is unread, status bit4 (overrun) is set and the buffer holds the new word. A read strobe on address 6 clears the unread flag (status bit5).
- R10: With monitor mode and clock-hold set, the block holds SCL low after the acknowledge clock while the interrupt is pending. It releases SCL once the interrupt is cleared.
- R11: Without both monitor mode and clock-hold enable, `scl_hold_o` never asserts.
- R12: Writing status with bit0 = 1 clears the interrupt and bit4 = 1 clears overrun. Writing 0 to those bits leaves them unchanged.
- R13: Control bits above bit2 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| scl_hold_o | output | 1 | 1 = pull SCL low (open-drain enable) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (consumes the buffer) |
| reg_addr_i | input | REG_AW | Register address |
| reg_wdata_i | input | REG_DW | Write data |
| reg_rdata_o | output | REG_DW | Combinational read data |
| irq_o | output | 1 | Interrupt pending |

## Verification
The bench sweeps all 128 addresses in three configurations: filtered, match-all, and match-all with monitor mode off. A matcher that compared the wrong bits, or that obeyed match-all outside monitor mode, raises interrupts on the wrong addresses. A wrong priority encoder reports the wrong index. Write and read transfers are checked byte by byte against both the data register and the buffer, including the acknowledge level, which catches an off-by-one shift or a swapped ACK bit. The bench also covers repeated START re-arbitration, overrun with an unread buffer, and SCL stretching that must end exactly when the interrupt is cleared. An open-drain model of the bus shows whether a master really stalls while SCL is held low.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef struct packed {
        logic all;   // bit2: match every address (monitor mode only)
        logic hold;  // bit1: allow SCL hold while interrupt pending
        logic mon;   // bit0: monitor mode
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
    end

    // idle bus level is high, so reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cmon_frame.sv
module i2cmon_frame #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    output logic              start_o,
    output logic              stop_o,
    output logic              word_o,
    output logic              first_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              ack_o,
    output logic              active_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              scl_p;
        logic              sda_p;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shift;
        logic              active;
        logic              first;
        logic              word;
        logic              wfirst;
        logic [DATA_W-1:0] wbyte;
        logic              ack;
    } fr_t;

    fr_t q, d;
    logic start_c, stop_c, rise_c;

    always_comb begin
        start_c = q.scl_p & scl & q.sda_p & ~sda;
        stop_c  = q.scl_p & scl & ~q.sda_p & sda;
        rise_c  = ~q.scl_p & scl;

        d       = q;
        d.scl_p = scl;
        d.sda_p = sda;
        d.word  = 1'b0;

        if (start_c) begin
            d.active = 1'b1;
            d.first  = 1'b1;
            d.cnt    = '0;
        end else if (stop_c) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end else if (rise_c && q.active) begin
            if (q.cnt == CNT_W'(DATA_W)) begin
                d.word   = 1'b1;
                d.wbyte  = q.shift;
                d.ack    = sda;
                d.wfirst = q.first;
                d.first  = 1'b0;
                d.cnt    = '0;
            end else begin
                d.shift = {q.shift[DATA_W-2:0], sda};
                d.cnt   = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign start_o  = start_c;
    assign stop_o   = stop_c;
    assign word_o   = q.word;
    assign first_o  = q.wfirst;
    assign byte_o   = q.wbyte;
    assign ack_o    = q.ack;
    assign active_o = q.active;
endmodule

// File: rtl/i2c_bus_listener.sv
module i2c_bus_listener
    import i2cmon_pkg::*;
#(
    parameter int NUM_ADDR    = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int REG_AW      = 3,
    parameter int REG_DW      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_hold_o,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int ADDR_W = DATA_W - 1;
    localparam int IDX_W  = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1;
    localparam int A_CTRL = 0;
    localparam int A_DATA = NUM_ADDR + 1;
    localparam int A_BUF  = NUM_ADDR + 2;
    localparam int A_STAT = NUM_ADDR + 3;
    localparam int ST_W   = 6 + IDX_W;

    typedef struct packed {
        ctrl_t                             ctrl;
        logic [NUM_ADDR-1:0][ADDR_W-1:0]   adr;
        logic [DATA_W-1:0]                 data;
        logic [DATA_W:0]                   buff;
        logic                              irq;
        logic                              rw;
        logic [IDX_W-1:0]                  idx;
        logic                              ovr;
        logic                              full;
        logic                              hit_reg;
        logic                              sel;
        logic                              hold;
    } st_t;

    st_t q, d;

    logic              scl_s, sda_s;
    logic              start_evt, stop_evt, word_evt, word_first, word_ack, bus_active;
    logic [DATA_W-1:0] word_byte;
    logic [NUM_ADDR-1:0] hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              buf_rd, clr_irq, take;
    logic [ST_W-1:0]   stat;
    int                a_int;

    i2cmon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    i2cmon_frame #(.DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_s),
        .sda      (sda_s),
        .start_o  (start_evt),
        .stop_o   (stop_evt),
        .word_o   (word_evt),
        .first_o  (word_first),
        .byte_o   (word_byte),
        .ack_o    (word_ack),
        .active_o (bus_active)
    );

    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_match
        assign hit[g] = (q.adr[g] == word_byte[DATA_W-1:1]);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ADDR - 1; i >= 0; i--)
            if (hit[i]) hit_idx = IDX_W'(i);
    end

    assign a_int   = int'(reg_addr_i);
    assign buf_rd  = reg_rd_i && (a_int == A_BUF);
    assign clr_irq = reg_wr_i && (a_int == A_STAT) && reg_wdata_i[0];
    assign stat    = {bus_active, q.hit_reg, q.full, q.ovr, q.idx, q.rw, q.irq};

    always_comb begin
        d    = q;
        take = 1'b0;

        if (reg_wr_i) begin
            if (a_int == A_CTRL) d.ctrl = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
            for (int i = 0; i < NUM_ADDR; i++)
                if (a_int == i + 1) d.adr[i] = reg_wdata_i[ADDR_W-1:0];
            if (a_int == A_STAT) begin
                if (reg_wdata_i[0]) d.irq = 1'b0;
                if (reg_wdata_i[4]) d.ovr = 1'b0;
            end
        end
        if (buf_rd) d.full = 1'b0;

        if (start_evt || stop_evt) d.sel = 1'b0;

        if (word_evt) begin
            if (word_first) begin
                if ((q.ctrl.mon && q.ctrl.all) || (|hit)) begin
                    take      = 1'b1;
                    d.sel     = 1'b1;
                    d.rw      = word_byte[0];
                    d.idx     = hit_idx;
                    d.hit_reg = |hit;
                end else begin
                    d.sel = 1'b0;
                end
            end else begin
                take = q.sel;
            end
        end

        if (take) begin
            d.irq  = 1'b1;
            d.data = word_byte;
            d.buff = {word_byte, word_ack};
            if (q.full && !buf_rd) d.ovr = 1'b1;
            d.full = 1'b1;
        end

        d.hold = q.ctrl.mon && q.ctrl.hold && q.irq && (q.hold || !scl_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (a_int == A_CTRL) reg_rdata_o[CTRL_W-1:0] = q.ctrl;
        for (int i = 0; i < NUM_ADDR; i++)
            if (a_int == i + 1) reg_rdata_o[ADDR_W-1:0] = q.adr[i];
        if (a_int == A_DATA) reg_rdata_o[DATA_W-1:0] = q.data;
        if (a_int == A_BUF)  reg_rdata_o[DATA_W:0]   = q.buff;
        if (a_int == A_STAT) reg_rdata_o[ST_W-1:0]   = stat;
    end

    assign irq_o      = q.irq;
    assign scl_hold_o = q.hold;
endmodule

// File: rtl/i2c_bus_listener_chk.sv
module i2c_bus_listener_chk #(
    parameter int NUM_ADDR = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic                hold,
    input logic                mon,
    input logic                hold_en,
    input logic                stop_evt,
    input logic                word_evt,
    input logic                first,
    input logic                sel,
    input logic                full,
    input logic                buf_rd,
    input logic                ovr,
    input logic                clr,
    input logic [NUM_ADDR-1:0] hit
);
    a_r11_no_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon && hold_en) |=> !hold);

    a_r10_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |=> !hold);

    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !irq) |=> !irq);

    a_r12_clear_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !word_evt) |=> !irq);

    a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (word_evt && !first && sel && full && !buf_rd) |=> ovr);

    a_r7_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (word_evt && !first && !sel && !irq) |=> !irq);

    a_r4_filter_without_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon && word_evt && first && (hit == '0) && !irq) |=> !irq);
endmodule

bind i2c_bus_listener i2c_bus_listener_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq_o),
    .hold     (scl_hold_o),
    .mon      (q.ctrl.mon),
    .hold_en  (q.ctrl.hold),
    .stop_evt (stop_evt),
    .word_evt (word_evt),
    .first    (word_first),
    .sel      (q.sel),
    .full     (q.full),
    .buf_rd   (buf_rd),
    .ovr      (q.ovr),
    .clr      (clr_irq),
    .hit      (hit)
);

// File: tb/i2c_bus_listener_bench.sv
module i2c_bus_listener_bench;
    localparam int CLK_P = 10;
    localparam int Q     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1, sda_sl = 1'b1;
    logic        scl_hold_o, irq_o;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    wire         scl_bus = scl_m & ~scl_hold_o;
    wire         sda_bus = sda_m & sda_sl;

    int tests = 0, fails = 0, hold_viol = 0;
    bit hold_allowed = 0, done = 0;
    logic [6:0] adr_tab [4] = '{7'h00, 7'h2C, 7'h55, 7'h7F};

    always #(CLK_P/2) clk = ~clk;

    i2c_bus_listener u_i2c_bus_listener (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_hold_o(scl_hold_o), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq_o)
    );

    always @(negedge clk) if (rst_n && scl_hold_o && !hold_allowed) hold_viol++;

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] v);
        @(negedge clk); reg_addr = 3'(a); reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        @(negedge clk); reg_addr = 3'(a); #1 v = reg_rdata;
    endtask

    task automatic rd_buf(output logic [31:0] v);
        @(negedge clk); reg_addr = 3'd6; reg_rd = 1'b1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic scl_up;
        scl_m = 1'b1;
        for (int g = 0; g < 4000 && !scl_bus; g++) tick(1);
    endtask

    task automatic drive_bit(input logic b, input bit by_slave);
        if (by_slave) begin sda_sl = b; sda_m = 1'b1; end
        else          begin sda_m = b; sda_sl = 1'b1; end
        tick(Q); scl_up; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic start_c;
        sda_sl = 1'b1; sda_m = 1'b1; tick(Q); scl_up; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic stop_c;
        sda_sl = 1'b1; sda_m = 1'b0; tick(Q); scl_up; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit by_slave, input logic ack_lvl);
        for (int i = 7; i >= 0; i--) drive_bit(b[i], by_slave);
        drive_bit(ack_lvl, !by_slave);
        sda_m = 1'b1; sda_sl = 1'b1;
    endtask

    function automatic int find_idx(input logic [6:0] a);
        for (int i = 0; i < 4; i++) if (adr_tab[i] == a) return i;
        return -1;
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(3); rst_n = 1'b1; tick(2);

        // R1 reset state
        rd_reg(0, v); check("R1 ctrl", v, 0);
        rd_reg(7, v); check("R1 status", v, 0);
        check("R1 irq", 32'(irq_o), 0);
        check("R1 hold", 32'(scl_hold_o), 0);

        // R13 reserved control bits
        wr_reg(0, 32'hFFFF_FFF8); rd_reg(0, v); check("R13 reserved", v, 0);

        for (int i = 0; i < 4; i++) wr_reg(i + 1, 32'(adr_tab[i]));

        // R2 / R3 / R4 sweeps over every address
        for (int m = 0; m < 3; m++) begin
            logic [31:0] cv;
            cv = (m == 0) ? 32'h1 : (m == 1) ? 32'h5 : 32'h4;
            wr_reg(0, cv);
            for (int a = 0; a < 128; a++) begin
                int  ix;
                bit  expi;
                ix   = find_idx(7'(a));
                expi = (ix >= 0) || (m == 1);
                start_c;
                send_byte({7'(a), 1'b0}, 1'b0, 1'b0);
                rd_reg(7, v);
                if (m == 0)      check("R2 filter irq", 32'(v[0]), 32'(expi));
                else if (m == 1) check("R3 match-all irq", 32'(v[0]), 32'(expi));
                else             check("R4 match-all ignored", 32'(v[0]), 32'(expi));
                if (expi) begin
                    logic [31:0] e;
                    e = {24'd0, 1'b1, (ix >= 0), 2'b00,
                         (ix >= 0) ? 2'(ix) : 2'd0, 1'b0, 1'b1};
                    check(m == 1 ? "R3 status" : "R2 status", v & 32'hCF, e);
                    wr_reg(7, 32'h11);
                end
                stop_c;
            end
        end
        rd_buf(v);
        wr_reg(7, 32'h11);

        // R4 hold ignored without monitor mode
        wr_reg(0, 32'h2);
        start_c; send_byte({7'h2C, 1'b0}, 1'b0, 1'b0); tick(4*Q);
        check("R4 hold ignored", 32'(scl_hold_o), 0);
        wr_reg(7, 32'h11); rd_buf(v); stop_c;

        // R5 write transfer
        wr_reg(0, 32'h1);
        start_c; send_byte({7'h2C, 1'b0}, 1'b0, 1'b0);
        wr_reg(7, 32'h11); rd_buf(v);
        begin
            logic [7:0] bs [2] = '{8'hA5, 8'h3C};
            logic       ak [2] = '{1'b0, 1'b1};
            for (int k = 0; k < 2; k++) begin
                send_byte(bs[k], 1'b0, ak[k]);
                check("R5 irq", 32'(irq_o), 1);
                rd_reg(5, v); check("R5 data", v, 32'(bs[k]));
                rd_buf(v);    check("R5 buffer", v, {23'd0, bs[k], ak[k]});
                rd_reg(7, v); check("R5 no overrun", 32'(v[4]), 0);
                // R12 writing zero leaves irq set
                wr_reg(7, 32'h0); check("R12 no clear on zero", 32'(irq_o), 1);
                wr_reg(7, 32'h1); check("R12 clear", 32'(irq_o), 0);
            end
        end
        stop_c;
        check("R8 stop no irq", 32'(irq_o), 0);
        rd_reg(7, v); check("R8 bus idle", 32'(v[7]), 0);

        // R6 read transfer
        start_c; send_byte({7'h55, 1'b1}, 1'b0, 1'b0);
        rd_reg(7, v); check("R6 rw flag", v & 32'h0F, 32'h0B);
        wr_reg(7, 32'h11); rd_buf(v);
        send_byte(8'hC3, 1'b1, 1'b0);
        rd_reg(5, v); check("R6 slave byte", v, 32'hC3);
        rd_buf(v);    check("R6 buffer", v, 32'h186);
        wr_reg(7, 32'h1);
        send_byte(8'h18, 1'b1, 1'b1);
        rd_buf(v);    check("R6 buffer nack", v, 32'h031);
        wr_reg(7, 32'h1);
        stop_c;

        // R7 unselected transfer stays quiet
        start_c; send_byte({7'h11, 1'b0}, 1'b0, 1'b1);
        send_byte(8'h99, 1'b0, 1'b0);
        check("R7 no irq", 32'(irq_o), 0);
        rd_reg(7, v); check("R8 bus active", 32'(v[7]), 1);
        // R8 repeated start re-evaluates address
        start_c; send_byte({7'h7F, 1'b0}, 1'b0, 1'b0);
        rd_reg(7, v); check("R8 repeated start", v & 32'h4F, 32'h4D);
        wr_reg(7, 32'h11); rd_buf(v);
        stop_c;
        check("R8 stop quiet", 32'(irq_o), 0);

        // R9 overrun
        start_c; send_byte({7'h00, 1'b0}, 1'b0, 1'b0);
        wr_reg(7, 32'h1);
        send_byte(8'h42, 1'b0, 1'b1);
        rd_reg(7, v); check("R9 overrun set", 32'(v[5:4]), 32'h3);
        rd_buf(v);    check("R9 newest word", v, 32'h085);
        rd_reg(7, v); check("R9 full cleared", 32'(v[5]), 0);
        wr_reg(7, 32'h11);
        rd_reg(7, v); check("R12 overrun cleared", 32'(v[4]), 0);
        stop_c;

        // R10 clock hold
        hold_allowed = 1;
        wr_reg(0, 32'h3);
        start_c; send_byte({7'h2C, 1'b0}, 1'b0, 1'b0);
        tick(2*Q);
        check("R10 hold asserted", 32'(scl_hold_o), 1);
        scl_m = 1'b1; tick(20);
        check("R10 bus held low", 32'(scl_bus), 0);
        wr_reg(7, 32'h11); tick(3);
        check("R10 released", 32'(scl_hold_o), 0);
        check("R10 bus high", 32'(scl_bus), 1);
        scl_m = 1'b0; tick(Q);
        rd_buf(v);
        wr_reg(0, 32'h1);
        hold_allowed = 0;
        stop_c;

        check("R11 no stray hold", 32'(hold_viol), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule